// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block keeps four alarm settings (minute, hour, day of month and day of week) and checks them against the current time that an external timekeeping core supplies in BCD. Each setting carries its own exclude bit. A field whose exclude bit is set plays no part in the comparison. A field whose exclude bit is clear must equal the matching time field. The check runs only when the timekeeping core pulses its update strobe. When every field that takes part matches, a sticky alarm flag is set. Only software can clear that flag.

An active-low interrupt line goes low while the flag is set and the interrupt enable is set. Software programs the block through a plain synchronous register port: it presents an address and write data with a write strobe, and read data follows the address combinationally. If all four fields are excluded, no alarm ever fires.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset the four alarm registers read 80h (field excluded, value 0), the control register reads 00h and `irq_n` is high.
- R2: The alarm registers are at 09h (minute), 0Ah (hour), 0Bh (day) and 0Ch (weekday). Bit 7 is the exclude bit. The value is kept in bits 6:0 for minute, 5:0 for hour and day, and 2:0 for weekday. Other bits are stored as 0 and read back as 0, which gives the write masks FFh, BFh, BFh and 87h.
- R3: The control register is at 01h. Bit 3 is the alarm flag and bit 1 is the interrupt enable. All other bits read 0.
- R4: On an update strobe, the alarm matches when every field with its exclude bit clear equals the current time field. Fields with the exclude bit set are ignored.
- R5: The comparison takes effect only in a cycle where the update strobe is high. A match without the strobe does not set the flag.
- R6: When all four exclude bits are 1, the flag is never set.
- R7: Once set, the flag stays 1. Writing 1 to bit 3 of the control register leaves the flag unchanged.
- R8: Writing 0 to bit 3 of the control register clears the flag one cycle later.
- R9: If a flag-clearing write and a match occur in the same cycle, the flag ends up set.
- R10: `irq_n` is low exactly when the flag and the enable are both 1. Clearing either one releases it high.
- R11: Addresses other than 01h and 09h–0Ch read 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one register per cycle |
| rdata | output | 8 | Read data for `addr`, combinational |
| tick | input | 1 | One-cycle time-update strobe |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current day of week |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions take for granted that `addr`, `wdata`, the time fields and both strobes hold defined levels at every rising edge once reset is released. They also assume that a write strobe names exactly one register. The flag checks treat the comparator's hit pulse as the only legitimate reason for the flag to rise, and they assume the time inputs stay steady through the cycle that carries the strobe. The bench changes every input only on the falling edge. In the randomized phase it keeps the time values and alarm values in a small range, so that matches, clearing writes and collisions between the two all occur often.

// File: rtl/cal_alarm_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and field-shape functions for the calendar alarm.
// Assumes one alarm register per field, laid out at consecutive addresses.
package cal_alarm_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 4;
    localparam int NUM_FIELDS  = 4;
    localparam int FIELD_MAX_W = 7;
    localparam int EXCL_BIT    = 7;
    localparam int FLAG_BIT    = 3;
    localparam int ENA_BIT     = 1;
    localparam int CTRL_ADDR   = 1;
    localparam int ALARM_BASE  = 9;

    typedef enum logic [1:0] {
        FLD_MIN  = 2'd0,
        FLD_HOUR = 2'd1,
        FLD_DAY  = 2'd2,
        FLD_WDAY = 2'd3
    } field_e;

    // Number of value bits kept for field idx.
    function automatic int field_width(input int idx);
        case (idx)
            0:       return 7;
            1, 2:    return 6;
            default: return 3;
        endcase
    endfunction

    // Mask of the bits a write keeps for field idx, exclude bit included.
    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < FIELD_MAX_W; b++)
            if (b < field_width(idx)) m[b] = 1'b1;
        m[EXCL_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/alarm_store.sv
`timescale 1ns/1ps
// Module: alarm_store
// Holds one alarm register per field. A write keeps only the exclude bit and
// the value bits defined for that field; the other bits are stored as zero.
// Assumes wr_en names a single address per cycle.
module alarm_store
    import cal_alarm_pkg::*;
#(
    parameter int NUM = NUM_FIELDS,
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int BASE = ALARM_BASE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    output logic [NUM-1:0][DW-1:0] regs_o
);
    localparam logic [DW-1:0] RESET_VAL = DW'(1) << EXCL_BIT;

    for (genvar i = 0; i < NUM; i++) begin : g_field
        localparam logic [AW-1:0]  MY_ADDR = AW'(BASE + i);
        localparam logic [DW-1:0]  MASK    = field_mask(i);
        logic [DW-1:0] val_q;
        logic          sel;

        assign sel = wr_en && (addr == MY_ADDR);

        // Load the masked write data, or return to the all-excluded state on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= RESET_VAL;
            else if (sel)
                val_q <= wdata & MASK;
        end

        assign regs_o[i] = val_q;
    end
endmodule

// File: rtl/alarm_match.sv
`timescale 1ns/1ps
// Module: alarm_match
// Masked comparison of the alarm fields against the current time. A hit
// pulse is produced only in a strobe cycle when at least one field takes part
// and every field that takes part is equal. Purely combinational.
module alarm_match
    import cal_alarm_pkg::*;
#(
    parameter int NUM = NUM_FIELDS,
    parameter int DW  = DATA_W,
    parameter int TW  = FIELD_MAX_W
) (
    input  logic [NUM-1:0][DW-1:0] regs_i,
    input  logic [NUM-1:0][TW-1:0] now_i,
    input  logic                   tick_i,
    output logic                   hit_o,
    output logic                   excl_all_o
);
    logic [NUM-1:0] excl;
    logic [NUM-1:0] field_ok;

    for (genvar i = 0; i < NUM; i++) begin : g_cmp
        localparam logic [DW-1:0] MASK = field_mask(i);
        localparam logic [TW-1:0] VMASK = MASK[TW-1:0];
        assign excl[i]     = regs_i[i][EXCL_BIT];
        // A field agrees when it is excluded or its value bits equal the time.
        assign field_ok[i] = excl[i] ||
                             ((regs_i[i][TW-1:0] & VMASK) == (now_i[i] & VMASK));
    end

    assign excl_all_o = &excl;
    assign hit_o      = tick_i && !excl_all_o && (&field_ok);
endmodule

// File: rtl/alarm_irq_ctl.sv
`timescale 1ns/1ps
// Module: alarm_irq_ctl
// Sticky alarm flag, interrupt enable and the active-low interrupt line.
// A hit takes priority over a clear request in the same cycle.
module alarm_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clr_i,
    input  logic ena_we_i,
    input  logic ena_val_i,
    output logic flag_o,
    output logic ena_o,
    output logic irq_n_o
);
    logic flag_q;
    logic ena_q;

    // Set on hit, clear on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    // Load the enable bit on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ena_q <= 1'b0;
        else if (ena_we_i)
            ena_q <= ena_val_i;
    end

    assign flag_o  = flag_q;
    assign ena_o   = ena_q;
    assign irq_n_o = !(flag_q && ena_q);

    assert_match_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> flag_q);
    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    assert_clear_drops_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit_i) |=> !flag_q);
endmodule

// File: rtl/cal_alarm_top.sv
`timescale 1ns/1ps
// Module: cal_alarm_top
// Calendar alarm comparator: register port, alarm storage, masked match and
// interrupt control. Assumes the time inputs are steady in strobe cycles.
module cal_alarm_top
    import cal_alarm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   wr_en,
    output logic [DATA_W-1:0]      rdata,
    input  logic                   tick,
    input  logic [6:0]             cur_min,
    input  logic [5:0]             cur_hour,
    input  logic [5:0]             cur_day,
    input  logic [2:0]             cur_wday,
    output logic                   irq_n
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] WDAY_A = ADDR_W'(ALARM_BASE + int'(FLD_WDAY));

    logic [NUM_FIELDS-1:0][DATA_W-1:0]      alarm_regs;
    logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] now_vec;
    logic hit, excl_all, ctl_we, flag, ena;

    assign now_vec[FLD_MIN]  = cur_min;
    assign now_vec[FLD_HOUR] = {1'b0, cur_hour};
    assign now_vec[FLD_DAY]  = {1'b0, cur_day};
    assign now_vec[FLD_WDAY] = {4'b0, cur_wday};
    assign ctl_we = wr_en && (addr == CTRL_A);

    alarm_store #(.NUM(NUM_FIELDS), .DW(DATA_W), .AW(ADDR_W), .BASE(ALARM_BASE)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .regs_o(alarm_regs)
    );

    alarm_match #(.NUM(NUM_FIELDS), .DW(DATA_W), .TW(FIELD_MAX_W)) u_match (
        .regs_i(alarm_regs), .now_i(now_vec), .tick_i(tick),
        .hit_o(hit), .excl_all_o(excl_all)
    );

    alarm_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .hit_i(hit),
        .clr_i(ctl_we && !wdata[FLAG_BIT]),
        .ena_we_i(ctl_we), .ena_val_i(wdata[ENA_BIT]),
        .flag_o(flag), .ena_o(ena), .irq_n_o(irq_n)
    );

    // Read multiplexer: control byte, alarm registers, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (addr == CTRL_A) begin
            rdata[FLAG_BIT] = flag;
            rdata[ENA_BIT]  = ena;
        end
        for (int i = 0; i < NUM_FIELDS; i++)
            if (addr == ADDR_W'(ALARM_BASE + i)) rdata = alarm_regs[i];
    end

    assert_tick_gates_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick));
    assert_all_excluded_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && excl_all) |=> !$rose(flag));
    assert_enable_clear_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !wdata[ENA_BIT]) |=> irq_n);
    assert_unused_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == WDAY_A) |-> (rdata[6:3] == 4'b0));
endmodule

// File: tb/tb_cal_alarm_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated at every rising edge and
// compared with irq_n and rdata at every falling edge.
module tb_cal_alarm_top;
    logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [6:0] t_min = 7'h0;
    logic [5:0] t_hour = 6'h0, t_day = 6'h0;
    logic [2:0] t_wday = 3'h0;
    logic [7:0] rdata;
    logic       irq_n;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    logic [7:0] m_al [4];
    bit m_af = 0, m_aie = 0;

    always #2.5 clk = ~clk;

    cal_alarm_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rdata(rdata), .tick(tick), .cur_min(t_min), .cur_hour(t_hour),
        .cur_day(t_day), .cur_wday(t_wday), .irq_n(irq_n)
    );

    function automatic logic [7:0] mask_of(int i);
        case (i) 0: return 8'hFF; 1, 2: return 8'hBF; default: return 8'h87; endcase
    endfunction

    function automatic logic [7:0] exp_rd(logic [3:0] a);
        if (a == 4'h1) return {4'b0, m_af, 1'b0, m_aie, 1'b0};
        if (a >= 4'h9 && a <= 4'hC) return m_al[a - 4'h9];
        return 8'h00;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_al[i] = 8'h80;
        m_af = 0; m_aie = 0;
    endtask

    // Next state of the reference model from the inputs seen at this edge.
    task automatic model_update();
        bit hit, all_ex;
        logic [7:0] nowv [4];
        nowv[0] = {1'b0, t_min}; nowv[1] = {2'b0, t_hour};
        nowv[2] = {2'b0, t_day}; nowv[3] = {5'b0, t_wday};
        all_ex = 1; hit = tick;
        for (int i = 0; i < 4; i++) begin
            if (!m_al[i][7]) begin
                all_ex = 0;
                if ((m_al[i] & mask_of(i) & 8'h7F) != (nowv[i] & mask_of(i) & 8'h7F)) hit = 0;
            end
        end
        if (all_ex) hit = 0;
        if (wr_en) begin
            if (addr == 4'h1) begin
                m_aie = wdata[1];
                if (!wdata[3]) m_af = 0;
            end else if (addr >= 4'h9 && addr <= 4'hC)
                m_al[addr - 4'h9] = wdata & mask_of(addr - 4'h9);
        end
        if (hit) m_af = 1;
    endtask

    task automatic step(bit we, logic [3:0] a, logic [7:0] d, bit tk);
        wr_en = we; addr = a; wdata = d; tick = tk;
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk(cur_req, {7'b0, irq_n}, {7'b0, !(m_af && m_aie)}, "irq_n");
        chk(cur_req, rdata, exp_rd(addr), "rdata");
        wr_en = 0; tick = 0;
    endtask

    task automatic read_all();
        step(0, 4'h1, 0, 0);
        for (int a = 9; a <= 12; a++) step(0, 4'(a), 0, 0);
    endtask

    task automatic set_time(logic [6:0] mi, logic [5:0] h, logic [5:0] dy, logic [2:0] w);
        t_min = mi; t_hour = h; t_day = dy; t_wday = w;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every register and the interrupt line
        cur_req = "R1"; read_all();
        // R2: masking of unused bits, field by field
        cur_req = "R2";
        step(1, 4'hC, 8'hFF, 0); step(1, 4'hB, 8'hFF, 0);
        step(1, 4'hA, 8'h7F, 0); step(1, 4'h9, 8'h7F, 0);
        // R3: control layout, reserved bits read zero
        cur_req = "R3"; step(1, 4'h1, 8'hFF, 0); step(1, 4'h1, 8'h02, 0);
        // R4: minute only takes part
        cur_req = "R4";
        step(1, 4'h9, 8'h30, 0); step(1, 4'hA, 8'h80, 0);
        step(1, 4'hB, 8'h80, 0); step(1, 4'hC, 8'h80, 0);
        set_time(7'h29, 6'h05, 6'h11, 3'd2); step(0, 4'h1, 0, 1);
        // R5: match without strobe is ignored
        cur_req = "R5"; set_time(7'h30, 6'h05, 6'h11, 3'd2); step(0, 4'h1, 0, 0);
        cur_req = "R4"; step(0, 4'h1, 0, 1);
        // R7: writing one to the flag keeps it
        cur_req = "R7"; step(1, 4'h1, 8'h0A, 0); step(0, 4'h1, 0, 0);
        // R8: writing zero clears
        cur_req = "R8"; step(1, 4'h1, 8'h02, 0); step(0, 4'h1, 0, 0);
        // R9: clear and match together
        cur_req = "R9"; step(1, 4'h1, 8'h02, 1); step(0, 4'h1, 0, 0);
        // R10: enable off releases the line, flag stays
        cur_req = "R10"; step(1, 4'h1, 8'h08, 0); step(1, 4'h1, 8'h0A, 0);
        step(1, 4'h1, 8'h00, 0); step(1, 4'h1, 8'h02, 1);
        // R6: everything excluded never fires
        cur_req = "R6"; step(1, 4'h1, 8'h02, 0); step(1, 4'h9, 8'hB0, 0);
        step(0, 4'h1, 0, 1); step(0, 4'h1, 0, 1);
        // R4: several fields, one mismatching then all equal
        cur_req = "R4";
        step(1, 4'h9, 8'h45, 0); step(1, 4'hA, 8'h12, 0); step(1, 4'hC, 8'h03, 0);
        set_time(7'h45, 6'h13, 6'h01, 3'd3); step(0, 4'h1, 0, 1);
        set_time(7'h45, 6'h12, 6'h01, 3'd3); step(0, 4'h1, 0, 1);
        // R11: unmapped addresses read zero and hold nothing
        cur_req = "R11"; step(1, 4'h5, 8'hFF, 0); step(1, 4'h0, 8'h00, 0);
        step(1, 4'hD, 8'h00, 0); read_all();
        // Randomized mix, all requirements against the model
        cur_req = "R4";
        for (int n = 0; n < 600; n++) begin
            logic [3:0] a;
            logic [7:0] d;
            case ($urandom % 6)
                0: a = 4'h1; 1: a = 4'h9; 2: a = 4'hA; 3: a = 4'hB; 4: a = 4'hC; default: a = 4'h6;
            endcase
            d = 8'($urandom);
            if (a == 4'h1) d[3] = ($urandom % 4 != 0);
            else d = d & 8'h83;
            set_time(7'($urandom % 4), 6'($urandom % 4), 6'($urandom % 4), 3'($urandom % 4));
            step(($urandom % 3) == 0, a, d, ($urandom % 2) == 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule